// File: doc/BRIEF.md
# SPI Master Controller with Byte-Wide Register Interface

This block is a serial-peripheral master driven by a host through four byte-wide registers behind a small request/acknowledge bus. The host sets the clock polarity, clock phase and bit-rate code in a control register. A write of a byte to the data register starts one 8-bit full-duplex exchange on `sck`, `mosi` and `miso`. When the exchange ends, the block raises a completion flag in the status register. It also raises an interrupt if that is enabled. The host then reads the byte that arrived on `miso` from the data register, and it clears the flag by writing a one to it.

The bus handshake works like a valid/ready pair with fixed timing. The host holds `req` with `wr`, `addr` and `wdata` stable. The block accepts the access on the first clock edge it sees `req` and returns `ack` high for exactly one cycle. `rdata` is valid in that same cycle. The host drops `req` in the cycle `ack` is high. If `req` stays high, the next access is taken one cycle after `ack` and not earlier, so back-pressure is a fixed one idle cycle. There is no wait state. Chip-select generation is not handled here.

Top module: `spi_host_ctrl`

## Requirements
- R1: Address 2'b00 selects control, 2'b01 status, 2'b10 data and 2'b11 extended control. Control and extended control read back exactly the byte last written. All registers read 0 after reset.
- R2: Each accepted access returns `ack` high for exactly one cycle, in the cycle after `req` is first seen. `ack` is never high without `req` in the previous cycle.
- R3: A data-register write launches one 8-bit exchange when control bit 6 (enable) is 1 and no exchange is running. The byte goes out on `mosi` most significant bit first.
- R4: After completion, a read of the data register returns the 8 bits sampled from `miso`, first sampled bit in bit 7.
- R5: Control bits 1:0 set the `sck` period to 2, 4, 16 or 32 system clocks for codes 00, 01, 10 and 11. Each exchange produces exactly 16 `sck` transitions.
- R6: Status bit 7 (done) sets in the cycle the last `sck` transition of an exchange takes place. Other status bits read 0.
- R7: A status write with bit 7 = 1 clears done. A status write with bit 7 = 0 leaves done unchanged.
- R8: `irq` is high exactly while done is 1 and control bit 7 (interrupt enable) is 1.
- R9: A data-register write while an exchange is running is ignored. The running exchange continues, and no second exchange follows it.
- R10: `sck` rests at control bit 3 (polarity) whenever no exchange runs. With control bit 2 (phase) = 0, data is sampled on the leading edge of each bit and `mosi` changes on the trailing edge. With phase = 1, `mosi` changes on the leading edge and data is sampled on the trailing edge.
- R11: A data-register write while control bit 6 is 0 starts nothing: `sck` stays idle and done stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Bus access request |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while `ack` is high |
| ack | output | 1 | One-cycle access acknowledge |
| irq | output | 1 | Completion interrupt |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The assertions assume the host drops `req` once `ack` is seen, so that each bus access is a single request. They also assume that polarity is not rewritten while an exchange runs. The rule that `sck` rests at the polarity level, and the rule that a one written to status clears done, both depend on this. The bench keeps to these assumptions: every access is a task that raises `req` for exactly one cycle. Control is written only while the block is idle, after the previous exchange has been confirmed complete by polling. The serial peripheral model in the bench drives `miso` from `sck` edges. The block samples `miso` at least one system clock after the edge that changed it.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'b00,
    REG_STAT = 2'b01,
    REG_DATA = 2'b10,
    REG_EXT  = 2'b11
  } reg_sel_e;

  // control field positions
  localparam int CTRL_IRQ_EN = 7;
  localparam int CTRL_ENABLE = 6;
  localparam int CTRL_CPOL   = 3;
  localparam int CTRL_CPHA   = 2;
  localparam int CTRL_RATE_L = 0;
  localparam int RATE_W      = 2;

  // status field position
  localparam int STAT_DONE = 7;

  // largest half-period is 2**MAX_SHIFT system clocks
  localparam int MAX_SHIFT = 4;

  // half-period exponent per rate code: 1, 2, 8, 16 clocks
  function automatic int unsigned rate_shift(input logic [RATE_W-1:0] code);
    case (code)
      2'd0:    return 0;
      2'd1:    return 1;
      2'd2:    return 3;
      default: return MAX_SHIFT;
    endcase
  endfunction

endpackage

// File: rtl/spi_host_clkdiv.sv
module spi_host_clkdiv
  import spi_host_pkg::*;
#(
  parameter int CNT_W = MAX_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  always_comb begin
    limit = CNT_W'((32'd1 << rate_shift(rate)) - 32'd1);
  end

  assign tick = run && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/spi_host_shifter.sv
module spi_host_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              cpha,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              sck_phase,
  output logic              mosi,
  output logic              xfer_done,
  output logic [DATA_W-1:0] rx_byte
);

  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES);

  logic [EW-1:0]     edge_q;
  logic [DATA_W-1:0] tx_sr, rx_sr, rx_next;
  logic              lead, last, sample, launch;

  // even edge index = leading edge of a bit
  assign lead   = ~edge_q[0];
  assign last   = (edge_q == EW'(EDGES - 1));
  assign sample = cpha ? ~lead : lead;
  assign launch = cpha ? (lead && (edge_q != '0)) : (~lead && !last);

  always_comb begin
    rx_next = sample ? {rx_sr[DATA_W-2:0], miso} : rx_sr;
  end

  assign xfer_done = busy && tick && last;
  assign mosi      = tx_sr[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      edge_q    <= '0;
      tx_sr     <= '0;
      rx_sr     <= '0;
      sck_phase <= 1'b0;
    end else if (start) begin
      busy      <= 1'b1;
      edge_q    <= '0;
      tx_sr     <= tx_byte;
      rx_sr     <= '0;
      sck_phase <= 1'b0;
    end else if (busy && tick) begin
      edge_q    <= edge_q + 1'b1;
      sck_phase <= ~sck_phase;
      rx_sr     <= rx_next;
      if (launch) tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
      if (last)   busy  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte <= '0;
    end else if (xfer_done) begin
      rx_byte <= rx_next;
    end
  end

endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_host_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ack,
  input  logic              busy,
  input  logic              xfer_done,
  input  logic [DATA_W-1:0] rx_byte,
  output logic              start,
  output logic              cpol,
  output logic              cpha,
  output logic [RATE_W-1:0] rate,
  output logic              done_flag,
  output logic              irq
);

  logic [DATA_W-1:0] ctrl_q, ext_q, stat_v, rd_mux;
  logic              acc, wr_acc, clr_done;

  assign acc      = req && !ack;
  assign wr_acc   = acc && wr;
  assign start    = wr_acc && (addr == REG_DATA) && ctrl_q[CTRL_ENABLE] && !busy;
  assign clr_done = wr_acc && (addr == REG_STAT) && wdata[STAT_DONE];

  assign cpol = ctrl_q[CTRL_CPOL];
  assign cpha = ctrl_q[CTRL_CPHA];
  assign rate = ctrl_q[CTRL_RATE_L +: RATE_W];
  assign irq  = done_flag && ctrl_q[CTRL_IRQ_EN];

  always_comb begin
    stat_v            = '0;
    stat_v[STAT_DONE] = done_flag;
    case (addr)
      REG_CTRL: rd_mux = ctrl_q;
      REG_STAT: rd_mux = stat_v;
      REG_DATA: rd_mux = rx_byte;
      default:  rd_mux = ext_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack   <= 1'b0;
      rdata <= '0;
    end else begin
      ack <= acc;
      if (acc && !wr) rdata <= rd_mux;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ext_q  <= '0;
    end else if (wr_acc) begin
      if (addr == REG_CTRL) ctrl_q <= wdata;
      if (addr == REG_EXT)  ext_q  <= wdata;
    end
  end

  // completion wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_flag <= 1'b0;
    end else if (xfer_done) begin
      done_flag <= 1'b1;
    end else if (clr_done) begin
      done_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ack,
  output logic              irq,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);

  logic              busy, start, tick, xfer_done, done_flag;
  logic              cpol, cpha, sck_phase;
  logic [RATE_W-1:0] rate;
  logic [DATA_W-1:0] rx_byte;

  spi_host_regs #(.DATA_W(DATA_W)) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .wr        (wr),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .ack       (ack),
    .busy      (busy),
    .xfer_done (xfer_done),
    .rx_byte   (rx_byte),
    .start     (start),
    .cpol      (cpol),
    .cpha      (cpha),
    .rate      (rate),
    .done_flag (done_flag),
    .irq       (irq)
  );

  spi_host_clkdiv #(.CNT_W(MAX_SHIFT)) i_clkdiv (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .rate  (rate),
    .tick  (tick)
  );

  spi_host_shifter #(.DATA_W(DATA_W)) i_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .tx_byte   (wdata),
    .cpha      (cpha),
    .tick      (tick),
    .miso      (miso),
    .busy      (busy),
    .sck_phase (sck_phase),
    .mosi      (mosi),
    .xfer_done (xfer_done),
    .rx_byte   (rx_byte)
  );

  assign sck = sck_phase ^ cpol;

endmodule

// File: rtl/spi_host_checker.sv
module spi_host_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              wr,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] wdata,
  input logic              ack,
  input logic              sck,
  input logic              cpol,
  input logic              busy,
  input logic              done_flag,
  input logic              xfer_done
);

  a_r2_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  a_r2_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(req));

  a_r10_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == cpol));

  a_r6_flag_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> ($past(busy) && !busy));

  a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack && wr && addr == 2'b01 && wdata[7] && !busy) |=> !done_flag);

  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer_done) |=> busy);

endmodule

bind spi_host_ctrl spi_host_checker #(.DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req       (req),
  .wr        (wr),
  .addr      (addr),
  .wdata     (wdata),
  .ack       (ack),
  .sck       (sck),
  .cpol      (cpol),
  .busy      (busy),
  .done_flag (done_flag),
  .xfer_done (xfer_done)
);

// File: tb/test_spi_host_ctrl.sv
`timescale 1ns/1ps
module test_spi_host_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'b00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       ack, irq, sck, mosi, miso;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;

  // serial peripheral model state
  logic       armed = 1'b0, m_cpol = 1'b0, m_cpha = 1'b0;
  logic [7:0] s_tx = 8'h00, s_rx = 8'h00;
  int         edges = 0, lead_n = 0, t1 = 0, gap = 0;
  logic [7:0] rd_val;
  logic       ack_seen, ack_after;

  always #5 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  spi_host_ctrl i_spi_host_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ack(ack), .irq(irq), .sck(sck), .mosi(mosi), .miso(miso)
  );

  assign miso = s_tx[7];

  always @(sck) begin
    if (armed) begin
      edges = edges + 1;
      if (edges == 1) t1 = cyc;
      if (edges == 2) gap = cyc - t1;
      if (!m_cpha) begin
        if (sck != m_cpol) s_rx = {s_rx[6:0], mosi};
        else               s_tx = {s_tx[6:0], 1'b0};
      end else begin
        if (sck != m_cpol) begin
          if (lead_n != 0) s_tx = {s_tx[6:0], 1'b0};
          lead_n = lead_n + 1;
        end else begin
          s_rx = {s_rx[6:0], mosi};
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    ack_seen = ack;
    req = 1'b0; wr = 1'b0;
    @(negedge clk);
    ack_after = ack;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    req = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk);
    ack_seen = ack;
    d = rdata;
    req = 1'b0;
    @(negedge clk);
    ack_after = ack;
  endtask

  task automatic wait_done();
    logic [7:0] s;
    s = 8'h00;
    for (int i = 0; i < 400 && !s[7]; i++) bus_read(2'b01, s);
  endtask

  task automatic arm(input logic cp, input logic ph, input logic [7:0] mi);
    m_cpol = cp; m_cpha = ph; s_tx = mi; s_rx = 8'h00;
    edges = 0; lead_n = 0; gap = 0;
    armed = 1'b1;
  endtask

  task automatic test_reset();
    chk("R10 sck idle after reset", sck, 0);
    chk("R8 irq after reset", irq, 0);
    chk("R2 ack after reset", ack, 0);
    bus_read(2'b00, rd_val); chk("R1 ctrl reset", rd_val, 8'h00);
    bus_read(2'b01, rd_val); chk("R1 status reset", rd_val, 8'h00);
    bus_read(2'b10, rd_val); chk("R1 data reset", rd_val, 8'h00);
  endtask

  task automatic test_regs();
    bus_write(2'b00, 8'h5B);
    chk("R2 ack on write", ack_seen, 1);
    chk("R2 ack single cycle", ack_after, 0);
    bus_read(2'b00, rd_val); chk("R1 ctrl readback", rd_val, 8'h5B);
    chk("R2 ack on read", ack_seen, 1);
    chk("R10 sck follows polarity when idle", sck, 1);
    bus_write(2'b11, 8'hA5);
    bus_read(2'b11, rd_val); chk("R1 ext readback", rd_val, 8'hA5);
    bus_write(2'b11, 8'h00);
    bus_read(2'b11, rd_val); chk("R1 ext readback zero", rd_val, 8'h00);
    bus_read(2'b00, rd_val); chk("R1 ctrl untouched by ext", rd_val, 8'h5B);
  endtask

  task automatic run_mode(input logic cp, input logic ph, input logic [1:0] rt,
                          input logic ie, input logic [7:0] mo, input logic [7:0] mi);
    logic [7:0] ctl;
    int per;
    ctl = {ie, 1'b1, 1'b0, 1'b1, cp, ph, rt};
    per = (rt == 2'd0) ? 2 : (rt == 2'd1) ? 4 : (rt == 2'd2) ? 16 : 32;
    bus_write(2'b00, ctl);
    arm(cp, ph, mi);
    bus_write(2'b10, mo);
    wait_done();
    chk($sformatf("R3 mosi byte cpol%0d cpha%0d rate%0d", cp, ph, rt), s_rx, mo);
    bus_read(2'b10, rd_val);
    chk($sformatf("R4 miso byte cpol%0d cpha%0d rate%0d", cp, ph, rt), rd_val, mi);
    chk($sformatf("R5 sck period rate%0d", rt), 2 * gap, per);
    chk("R5 sck transitions", edges, 16);
    chk("R10 sck back at polarity", sck, cp);
    bus_read(2'b01, rd_val); chk("R6 done flag", rd_val, 8'h80);
    chk("R8 irq while done", irq, ie);
    bus_write(2'b01, 8'h80);
    bus_read(2'b01, rd_val); chk("R7 cleared by one", rd_val, 8'h00);
    chk("R8 irq after clear", irq, 0);
    armed = 1'b0;
  endtask

  task automatic test_w1c_zero();
    bus_write(2'b00, 8'hD0);
    arm(1'b0, 1'b0, 8'h3C);
    bus_write(2'b10, 8'h96);
    wait_done();
    bus_write(2'b01, 8'h7F);
    bus_read(2'b01, rd_val); chk("R7 zero in bit7 keeps done", rd_val, 8'h80);
    chk("R8 irq still high", irq, 1);
    bus_write(2'b01, 8'hFF);
    bus_read(2'b01, rd_val); chk("R7 one clears done", rd_val, 8'h00);
    armed = 1'b0;
  endtask

  task automatic test_busy_write();
    bus_write(2'b00, 8'h51);
    arm(1'b0, 1'b0, 8'hE7);
    bus_write(2'b10, 8'hC3);
    bus_write(2'b10, 8'h18);
    wait_done();
    chk("R9 first byte kept", s_rx, 8'hC3);
    bus_read(2'b10, rd_val); chk("R9 rx of first exchange", rd_val, 8'hE7);
    repeat (60) @(negedge clk);
    chk("R9 no second exchange", edges, 16);
    bus_write(2'b01, 8'h80);
    armed = 1'b0;
  endtask

  task automatic test_disabled();
    bus_write(2'b00, 8'h10);
    arm(1'b0, 1'b0, 8'hAA);
    bus_write(2'b10, 8'h55);
    repeat (80) @(negedge clk);
    chk("R11 no sck while disabled", edges, 0);
    bus_read(2'b01, rd_val); chk("R11 done stays clear", rd_val, 8'h00);
    armed = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_reset();
    test_regs();
    for (int m = 0; m < 4; m++) begin
      for (int r = 0; r < 4; r++) begin
        run_mode(m[1], m[0], r[1:0], r[0], 8'h80 ^ 8'(m * 37 + r * 11),
                 8'h01 ^ 8'(m * 53 + r * 29));
      end
    end
    test_w1c_zero();
    test_busy_write();
    test_disabled();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule